// File: doc/BRIEF.md
# MPLS Label Lookup and Header Rewrite

This block is the forwarding table of a label switching router. It holds a small set of entries. Each entry binds an incoming 20-bit label to an action, an outgoing label and an egress port number. A controller presents the first 32-bit shim word of a packet together with a one-cycle request. Two cycles later the block answers with a one-cycle done pulse. With that pulse it returns one of two results:

- a forwarded result: the rewritten shim word or words, the egress port, and the bottom-of-stack flag for a pop;
- a drop indication.

Only the incoming label selects the entry. No other header field takes part in the search.

Software fills the table through a simple word-addressed register port. Every implemented bit can be read back combinationally. Three actions are supported:

- replace the label (swap);
- add a new outer word (push);
- remove the word (pop).

Every forwarded word carries a TTL one lower than the incoming word.

Top module: `mpls_label_rewrite`

## Requirements
- R1: The shim word layout is label in bits [31:12], EXP in bits [11:9], bottom-of-stack flag S in bit 8, and TTL in bits [7:0], on both the lookup input and the result words.
- R2: The configuration address is {entry index, select[1:0]}. Select 0 holds the match label in bits [19:0] and the entry enable in bit 31. Select 1 holds the outgoing label in bits [19:0]. Select 2 holds the action in bits [1:0] (0 none, 1 swap, 2 push, 3 pop) and the egress port in bits [10:8]. Select 3 holds nothing. A write stores only these bits, and reading an address returns the stored bits with every other bit zero, in the same cycle.
- R3: Among enabled entries whose match label equals the incoming label, the entry with the lowest index is used. Disabled entries never match.
- R4: Swap returns one word: the outgoing label, the incoming EXP and S, and the decremented TTL.
- R5: Push returns two words. Word 0 is new: the outgoing label, the incoming EXP, S=0 and the decremented TTL. Word 1 is the incoming word with only its TTL decremented.
- R6: Pop returns zero words and reports the incoming S flag on the bottom-of-stack output.
- R7: A matched lookup whose incoming TTL is 0 or 1 is dropped. Otherwise every returned word carries the incoming TTL minus one.
- R8: A lookup that matches no enabled entry, or that matches an entry whose action is none, is dropped.
- R9: Done is high exactly two cycles after a request, for one cycle. With done high, exactly one of valid or drop is high. With done low, both are low and all result outputs are zero. On a drop, the word count, words, port and bottom-of-stack output are zero.
- R10: After reset every configuration address reads zero, all entries are disabled, and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Entry index and field select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back data for cfg_addr |
| lk_req | input | 1 | Lookup request pulse |
| lk_shim | input | 32 | Incoming shim word |
| lk_done | output | 1 | Result pulse, two cycles after request |
| lk_valid | output | 1 | Packet forwarded |
| lk_drop | output | 1 | Packet dropped (miss, no action, TTL expiry) |
| lk_nwords | output | 2 | Number of result words (0, 1 or 2) |
| lk_word0 | output | 32 | First (outer) result word |
| lk_word1 | output | 32 | Second result word on push |
| lk_port | output | 3 | Egress port |
| lk_bos | output | 1 | Incoming S flag on a pop |

## Verification
A corrupted entry register shows up at once on the combinational read-back. It also shows up on the next lookup that selects the entry: the next done pulse carries the wrong label, port or action. A broken priority or enable bit appears when two entries share a label and the higher-index entry's outgoing label is returned instead. A slip in the two-stage pipeline moves the done pulse off its fixed cycle, or pairs the result with a neighbouring request. A wrong TTL path shows either as a drop that should have been forwarded or as a result word whose low byte differs from the incoming TTL less one.

// File: rtl/mlr_pkg.sv
package mlr_pkg;
   localparam int SHIM_W = 32;
   localparam int LBL_W  = 20;
   localparam int EXP_W  = 3;
   localparam int TTL_W  = 8;

   // R1 field layout, outer bits first
   typedef struct packed {
      logic [LBL_W-1:0] label;
      logic [EXP_W-1:0] exp;
      logic             bos;
      logic [TTL_W-1:0] ttl;
   } shim_t;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_SWAP = 2'd1,
      ACT_PUSH = 2'd2,
      ACT_POP  = 2'd3
   } act_e;

   localparam logic [1:0] SEL_KEY = 2'd0;
   localparam logic [1:0] SEL_NXT = 2'd1;
   localparam logic [1:0] SEL_CTL = 2'd2;
   localparam int EN_BIT   = 31;
   localparam int PORT_LSB = 8;
endpackage

// File: rtl/mlr_table.sv
module mlr_table
   import mlr_pkg::*;
#(
   parameter  int N_ENTRIES = 8,
   parameter  int PORT_W    = 3,
   localparam int IDX_W     = $clog2(N_ENTRIES),
   localparam int ADDR_W    = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [N_ENTRIES-1:0] ent_en,
   output logic [LBL_W-1:0]  ent_key  [N_ENTRIES],
   output logic [LBL_W-1:0]  ent_nxt  [N_ENTRIES],
   output logic [1:0]        ent_act  [N_ENTRIES],
   output logic [PORT_W-1:0] ent_port [N_ENTRIES]
);
   logic [IDX_W-1:0] idx;
   logic [1:0]       sel;
   logic             en_q [N_ENTRIES];

   assign idx = addr[ADDR_W-1:2];
   assign sel = addr[1:0];

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[i]     <= 1'b0;
            ent_key[i]  <= '0;
            ent_nxt[i]  <= '0;
            ent_act[i]  <= '0;
            ent_port[i] <= '0;
         end else if (we && idx == IDX_W'(i)) begin
            case (sel)
               SEL_KEY: begin
                  en_q[i]    <= wdata[EN_BIT];
                  ent_key[i] <= wdata[LBL_W-1:0];
               end
               SEL_NXT: ent_nxt[i] <= wdata[LBL_W-1:0];
               SEL_CTL: begin
                  ent_act[i]  <= wdata[1:0];
                  ent_port[i] <= wdata[PORT_LSB +: PORT_W];
               end
               default: ;
            endcase
         end
      end
      assign ent_en[i] = en_q[i];
   end

   // R2 read-back: implemented bits only
   always_comb begin
      rdata = '0;
      if (int'(idx) < N_ENTRIES) begin
         case (sel)
            SEL_KEY: begin
               rdata[LBL_W-1:0] = ent_key[idx];
               rdata[EN_BIT]    = en_q[idx];
            end
            SEL_NXT: rdata[LBL_W-1:0] = ent_nxt[idx];
            SEL_CTL: begin
               rdata[1:0]                = ent_act[idx];
               rdata[PORT_LSB +: PORT_W] = ent_port[idx];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mlr_match.sv
module mlr_match
   import mlr_pkg::*;
#(
   parameter  int N_ENTRIES = 8,
   localparam int IDX_W     = $clog2(N_ENTRIES)
) (
   input  logic [N_ENTRIES-1:0] ent_en,
   input  logic [LBL_W-1:0]     ent_key [N_ENTRIES],
   input  logic [LBL_W-1:0]     label,
   output logic                 hit,
   output logic [IDX_W-1:0]     hit_idx
);
   logic [N_ENTRIES-1:0] eq;

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
      assign eq[i] = ent_en[i] && (ent_key[i] == label);
   end

   // R3: scan downward so the lowest index is the last one written
   always_comb begin
      hit_idx = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (eq[i]) hit_idx = IDX_W'(i);
      end
      hit = |eq;
   end

   always_comb begin
      if (hit) begin
         AST_HIT_ENTRY_AGREES: assert (ent_en[hit_idx] && ent_key[hit_idx] == label); // R3
      end
   end
endmodule

// File: rtl/mlr_rewrite.sv
module mlr_rewrite
   import mlr_pkg::*;
#(
   parameter int PORT_W = 3
) (
   input  logic              hit,
   input  logic [1:0]        act,
   input  logic [LBL_W-1:0]  nxt,
   input  logic [PORT_W-1:0] port_in,
   input  shim_t             shim_in,
   output logic              fwd,
   output logic [1:0]        nwords,
   output shim_t             w0,
   output shim_t             w1,
   output logic [PORT_W-1:0] port_out,
   output logic              bos_out
);
   logic             ttl_ok;
   logic [TTL_W-1:0] ttl_dec;
   act_e             a;

   assign a       = act_e'(act);
   assign ttl_ok  = shim_in.ttl > TTL_W'(1);
   assign ttl_dec = shim_in.ttl - TTL_W'(1);
   assign fwd     = hit && (a != ACT_NONE) && ttl_ok;

   always_comb begin
      nwords   = 2'd0;
      w0       = '0;
      w1       = '0;
      port_out = '0;
      bos_out  = 1'b0;
      if (fwd) begin
         port_out = port_in;
         unique case (a)
            ACT_SWAP: begin
               nwords = 2'd1;
               w0     = '{label: nxt, exp: shim_in.exp, bos: shim_in.bos, ttl: ttl_dec};
            end
            ACT_PUSH: begin
               nwords = 2'd2;
               w0     = '{label: nxt, exp: shim_in.exp, bos: 1'b0, ttl: ttl_dec};
               w1     = '{label: shim_in.label, exp: shim_in.exp, bos: shim_in.bos, ttl: ttl_dec};
            end
            ACT_POP: bos_out = shim_in.bos;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mpls_label_rewrite.sv
module mpls_label_rewrite
   import mlr_pkg::*;
#(
   parameter  int N_ENTRIES = 8,
   parameter  int PORT_W    = 3,
   localparam int IDX_W     = $clog2(N_ENTRIES),
   localparam int ADDR_W    = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              lk_req,
   input  logic [31:0]       lk_shim,
   output logic              lk_done,
   output logic              lk_valid,
   output logic              lk_drop,
   output logic [1:0]        lk_nwords,
   output logic [31:0]       lk_word0,
   output logic [31:0]       lk_word1,
   output logic [PORT_W-1:0] lk_port,
   output logic              lk_bos
);
   if (N_ENTRIES < 2 || (1 << IDX_W) != N_ENTRIES) begin : g_bad_depth
      $error("N_ENTRIES must be a power of two, at least 2");
   end
   if (PORT_W < 1 || PORT_W > 8) begin : g_bad_port
      $error("PORT_W must lie in 1..8");
   end

   logic [N_ENTRIES-1:0] ent_en;
   logic [LBL_W-1:0]     ent_key  [N_ENTRIES];
   logic [LBL_W-1:0]     ent_nxt  [N_ENTRIES];
   logic [1:0]           ent_act  [N_ENTRIES];
   logic [PORT_W-1:0]    ent_port [N_ENTRIES];
   logic                 hit;
   logic [IDX_W-1:0]     hit_idx;
   shim_t                in_shim;

   assign in_shim = shim_t'(lk_shim);

   mlr_table #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_table (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .ent_en(ent_en),
      .ent_key(ent_key), .ent_nxt(ent_nxt), .ent_act(ent_act),
      .ent_port(ent_port)
   );

   mlr_match #(.N_ENTRIES(N_ENTRIES)) u_match (
      .ent_en(ent_en), .ent_key(ent_key), .label(in_shim.label),
      .hit(hit), .hit_idx(hit_idx)
   );

   // stage 1: capture the selected entry with the header
   logic              s1_v, s1_hit;
   logic [1:0]        s1_act;
   logic [LBL_W-1:0]  s1_nxt;
   logic [PORT_W-1:0] s1_port;
   shim_t             s1_shim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_hit  <= 1'b0;
         s1_act  <= '0;
         s1_nxt  <= '0;
         s1_port <= '0;
         s1_shim <= '0;
      end else begin
         s1_v <= lk_req;
         if (lk_req) begin
            s1_hit  <= hit;
            s1_act  <= ent_act[hit_idx];
            s1_nxt  <= ent_nxt[hit_idx];
            s1_port <= ent_port[hit_idx];
            s1_shim <= in_shim;
         end
      end
   end

   logic              rw_fwd, rw_bos;
   logic [1:0]        rw_nwords;
   shim_t             rw_w0, rw_w1;
   logic [PORT_W-1:0] rw_port;

   mlr_rewrite #(.PORT_W(PORT_W)) u_rewrite (
      .hit(s1_hit), .act(s1_act), .nxt(s1_nxt), .port_in(s1_port),
      .shim_in(s1_shim), .fwd(rw_fwd), .nwords(rw_nwords),
      .w0(rw_w0), .w1(rw_w1), .port_out(rw_port), .bos_out(rw_bos)
   );

   // stage 2: registered result, zero outside the done pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_done   <= 1'b0;
         lk_valid  <= 1'b0;
         lk_drop   <= 1'b0;
         lk_nwords <= '0;
         lk_word0  <= '0;
         lk_word1  <= '0;
         lk_port   <= '0;
         lk_bos    <= 1'b0;
      end else begin
         lk_done   <= s1_v;
         lk_valid  <= s1_v && rw_fwd;
         lk_drop   <= s1_v && !rw_fwd;
         lk_nwords <= s1_v ? rw_nwords : 2'd0;
         lk_word0  <= s1_v ? 32'(rw_w0) : 32'd0;
         lk_word1  <= s1_v ? 32'(rw_w1) : 32'd0;
         lk_port   <= s1_v ? rw_port : '0;
         lk_bos    <= s1_v && rw_bos;
      end
   end

   AST_DONE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> $past(lk_req, 2)); // R9
   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> ##1 lk_done); // R9
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> (lk_valid ^ lk_drop)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_done |-> (!lk_valid && !lk_drop && lk_nwords == 2'd0)); // R9
   AST_PUSH_OUTER_NOT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_nwords == 2'd2) |-> !lk_word0[8]); // R5
   AST_TTL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_nwords != 2'd0) |->
         (lk_word0[7:0] == $past(lk_shim[7:0], 2) - 8'd1 && lk_word0[7:0] != 8'd0)); // R7
   AST_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      lk_drop |-> (lk_nwords == 2'd0 && lk_word0 == 32'd0 && !lk_bos)); // R9
endmodule

// File: tb/mpls_label_rewrite_test.sv
module mpls_label_rewrite_test;
   localparam int CLK_PERIOD = 10;
   localparam int NE = 8;
   localparam int PW = 3;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          lk_req = 1'b0;
   logic [31:0]   lk_shim = '0;
   logic          lk_done, lk_valid, lk_drop, lk_bos;
   logic [1:0]    lk_nwords;
   logic [31:0]   lk_word0, lk_word1;
   logic [PW-1:0] lk_port;

   int n_chk = 0;
   int n_bad = 0;

   // bench copy of the table, filled from the requirement text
   logic          m_en   [NE];
   logic [19:0]   m_key  [NE];
   logic [19:0]   m_nxt  [NE];
   logic [1:0]    m_act  [NE];
   logic [PW-1:0] m_port [NE];

   always #(CLK_PERIOD/2) clk = ~clk;

   mpls_label_rewrite #(.N_ENTRIES(NE), .PORT_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_req(lk_req),
      .lk_shim(lk_shim), .lk_done(lk_done), .lk_valid(lk_valid),
      .lk_drop(lk_drop), .lk_nwords(lk_nwords), .lk_word0(lk_word0),
      .lk_word1(lk_word1), .lk_port(lk_port), .lk_bos(lk_bos)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_rd(input int idx, input int sel);
      case (sel)
         0: return {m_en[idx], 11'd0, m_key[idx]};
         1: return {12'd0, m_nxt[idx]};
         2: return {21'd0, m_port[idx], 6'd0, m_act[idx]};
         default: return 32'd0;
      endcase
   endfunction

   task automatic cfg_write(input int idx, input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'({idx[2:0], sel[1:0]}); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         0: begin m_en[idx] = d[31]; m_key[idx] = d[19:0]; end
         1: m_nxt[idx] = d[19:0];
         2: begin m_act[idx] = d[1:0]; m_port[idx] = d[8 +: PW]; end
         default: ;
      endcase
   endtask

   task automatic cfg_check(input int idx, input int sel);
      cfg_addr = AW'({idx[2:0], sel[1:0]});
      #1;
      chk("R2 readback", {32'd0, cfg_rdata}, {32'd0, model_rd(idx, sel)});
   endtask

   task automatic lookup(input logic [31:0] sh);
      int hi;
      logic v, d, b;
      logic [1:0] nw;
      logic [31:0] w0, w1;
      logic [PW-1:0] p;
      string tag;
      hi = -1;
      for (int i = NE - 1; i >= 0; i--) if (m_en[i] && m_key[i] == sh[31:12]) hi = i;
      v = 0; d = 1; b = 0; nw = 0; w0 = 0; w1 = 0; p = 0;
      if (hi < 0) tag = "R8 miss";
      else if (m_act[hi] == 2'd0) tag = "R8 no action";
      else if (sh[7:0] <= 8'd1) tag = "R7 ttl drop";
      else begin
         v = 1; d = 0; p = m_port[hi];
         case (m_act[hi])
            2'd1: begin tag = "R4 swap"; nw = 1;
                     w0 = {m_nxt[hi], sh[11:8], sh[7:0] - 8'd1}; end
            2'd2: begin tag = "R5 push"; nw = 2;
                     w0 = {m_nxt[hi], sh[11:9], 1'b0, sh[7:0] - 8'd1};
                     w1 = {sh[31:8], sh[7:0] - 8'd1}; end
            default: begin tag = "R6 pop"; b = sh[8]; end
         endcase
      end
      @(negedge clk);
      chk("R9 idle before request", {63'd0, lk_done}, 64'd0);
      lk_req = 1'b1; lk_shim = sh;
      @(negedge clk);
      lk_req = 1'b0;
      chk("R9 not done after one cycle", {63'd0, lk_done}, 64'd0);
      @(negedge clk);
      chk({tag, " flags"}, {56'd0, lk_done, lk_valid, lk_drop, lk_nwords, lk_port, lk_bos},
          {56'd0, 1'b1, v, d, nw, p, b});
      chk({tag, " words"}, {lk_word0, lk_word1}, {w0, w1});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int r;
      r = $urandom(32'd1337);
      for (int i = 0; i < NE; i++) begin
         m_en[i] = 0; m_key[i] = 0; m_nxt[i] = 0; m_act[i] = 0; m_port[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 done low", {61'd0, lk_done, lk_valid, lk_drop}, 64'd0);
      for (int i = 0; i < NE; i++)
         for (int s = 0; s < 4; s++) begin
            cfg_addr = AW'({i[2:0], s[1:0]}); #1;
            chk("R10 table cleared", {32'd0, cfg_rdata}, 64'd0);
         end
      lookup({20'h00ABC, 3'd5, 1'b1, 8'd64}); // R8 all disabled

      // R2 masking and the empty select
      cfg_write(0, 0, 32'h7FF0_0ABC | 32'h8000_0000); cfg_check(0, 0);
      cfg_write(0, 1, 32'hFFF1_2345);                 cfg_check(0, 1);
      cfg_write(0, 2, 32'hFFFF_FD01);                 cfg_check(0, 2);
      cfg_write(0, 3, 32'hFFFF_FFFF);                 cfg_check(0, 3);

      // R4 swap, port 5
      cfg_write(0, 2, 32'h0000_0501);
      lookup({20'h00ABC, 3'd5, 1'b1, 8'd64});
      // R3 duplicate label at entry 1 with push: entry 0 still wins
      cfg_write(1, 0, 32'h8000_0ABC);
      cfg_write(1, 1, 32'h0000_0777);
      cfg_write(1, 2, 32'h0000_0302);
      lookup({20'h00ABC, 3'd2, 1'b0, 8'd9});
      // R3 disabled entry 0 no longer matches; R5 push from entry 1
      cfg_write(0, 0, 32'h0000_0ABC);
      lookup({20'h00ABC, 3'd6, 1'b1, 8'd200});
      // R6 pop reports S
      cfg_write(2, 0, 32'h8000_0777);
      cfg_write(2, 2, 32'h0000_0203);
      lookup({20'h00777, 3'd0, 1'b1, 8'd5});
      lookup({20'h00777, 3'd0, 1'b0, 8'd5});
      // R7 TTL edges
      lookup({20'h00777, 3'd1, 1'b1, 8'd1});
      lookup({20'h00ABC, 3'd1, 1'b1, 8'd0});
      lookup({20'h00ABC, 3'd1, 1'b1, 8'd2});
      lookup({20'h00ABC, 3'd1, 1'b1, 8'd255});
      // R8 action none and plain miss
      cfg_write(3, 0, 32'h8000_0555);
      lookup({20'h00555, 3'd0, 1'b0, 8'd50});
      lookup({20'hFFFFF, 3'd0, 1'b0, 8'd50});

      // random mix over a small label pool so hits and duplicates occur
      for (int it = 0; it < 400; it++) begin
         int kind;
         kind = int'($urandom % 10);
         if (kind < 3) begin
            int idx, sel;
            logic [31:0] d;
            idx = int'($urandom % NE);
            sel = int'($urandom % 4);
            d = $urandom;
            if (sel == 0) d[19:0] = 20'h10 + 20'($urandom % 4);
            cfg_write(idx, sel, d);
            cfg_check(idx, sel);
         end else begin
            logic [31:0] sh;
            sh = $urandom;
            if ($urandom % 4 != 0) sh[31:12] = 20'h10 + 20'($urandom % 4);
            if ($urandom % 5 == 0) sh[7:0] = 8'($urandom % 3);
            lookup(sh);
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule